// File: doc/BRIEF.md
# Request-Driven SPI Target Endpoint

This block is the target end of a five-wire SPI link: the usual clock, active-low select, controller-out and controller-in lines, plus a request line that the target drives. Instead of waiting to be polled, the target fills a small local buffer with 16-bit words and raises its request line. The controller answers with a grant message on MOSI. The target then drops the request, turns on its MISO driver with the first word already loaded, and streams the buffered words while select is low. Outside a granted transfer the MISO driver stays off, so several targets can share one MISO wire.

Every message on MOSI starts with a header word. Each message is decoded when select rises. A grant message starts the send sequence. A parameter message loads a signed complex constant (real and imaginary parts). Malformed messages are dropped. If no grant comes within a timeout, the request is withdrawn, the buffer is flushed and an error flag is set. SCK, select and MOSI are brought onto the block clock through two-flop synchronizers. The link uses SPI mode 0, with words sent MSB first.

The state machine has five states. In `ST_IDLE` the target listens and accepts buffer writes; `send_start` with a non-empty buffer moves it to `ST_REQ`. In `ST_REQ` the request is high and the target listens. A grant moves it to `ST_ARM`, and timeout expiry returns it to `ST_IDLE`. `ST_ARM` lasts one cycle: it preloads word 0, enables MISO and moves to `ST_SEND`. In `ST_SEND` the target streams words; once the last word has been shifted out it moves to `ST_DONE`. `ST_DONE` keeps MISO driven until select is seen high, then returns to `ST_IDLE` and empties the buffer.

Top module: `spi_req_target`

## Requirements
- R1: After reset, `irq`, `miso_oe`, `tx_err`, `c_re` and `c_im` are all 0.
- R2: `send_start` in idle with at least one buffered word raises `irq`. `send_start` with an empty buffer leaves `irq` low. The buffer is empty again after every completed send.
- R3: A grant message (two words: 0xA5A5 then 0x0001), received while a request is pending, drops `irq` and raises `miso_oe`. MISO then carries the MSB of buffered word 0 before select falls.
- R4: During the granted frame, buffered words appear on `miso_out` in write order. They are MSB first, change after a falling SCK and are valid for the controller at each rising SCK. Once the last word is done and select is high, `miso_oe` returns to 0.
- R5: A parameter message (four words: 0xA5A5, 0x0002, real part, imaginary part) loads `c_re` and `c_im` when select rises.
- R6: A message is dropped with no effect on `c_re`, `c_im`, `irq` or `miso_oe` if its header is wrong, its command code is unknown, its word count does not fit its command, or it ends partway through a word.
- R7: If no grant arrives within `TIMEOUT_CYC` clocks of the request, `irq` falls, the buffer is flushed and `tx_err` is set. `tx_err` clears on the next `send_start` in idle.
- R8: A grant message received while no request is pending leaves `miso_oe` low.
- R9: MOSI content during a granted send is ignored; a valid parameter pattern clocked in then leaves `c_re` and `c_im` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_we | input | 1 | Append `buf_wdata` to the send buffer (idle only) |
| buf_wdata | input | 16 | Word to append |
| send_start | input | 1 | Request a transfer of the buffered words |
| sck | input | 1 | SPI clock from the controller |
| cs_n | input | 1 | Active-low select from the controller |
| mosi | input | 1 | Controller-to-target data |
| miso_out | output | 1 | Target-to-controller data value |
| miso_oe | output | 1 | MISO driver enable; high only during a granted transfer |
| irq | output | 1 | Transfer request to the controller |
| c_re | output | 16 | Stored real part of the constant (signed) |
| c_im | output | 16 | Stored imaginary part of the constant (signed) |
| tx_err | output | 1 | Grant timeout flag |

## Verification
The hardest situation to reach is a granted send in which MOSI carries a complete, valid parameter message. The bench creates it by clocking header, command and payload on MOSI during the data frame, then confirms that the constant did not move. The grant-timeout path is also hard to reach with a realistic timeout. The bench overrides `TIMEOUT_CYC` with a small value, lets a request expire, and then sends a late grant and an empty `send_start` to show that the buffer was really flushed.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] HDR_WORD  = 16'hA5A5;
    localparam logic [WORD_W-1:0] CMD_GRANT = 16'h0001;
    localparam logic [WORD_W-1:0] CMD_CSET  = 16'h0002;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ARM,
        ST_SEND,
        ST_DONE
    } tgt_state_t;
endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_req_shift.sv
module spi_req_shift
    import spi_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_preload,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_clean,
    output logic              tx_take,
    output logic              tx_bit
);
    localparam int CW = $clog2(WORD_W);

    logic              sck_q, cs_q;
    logic              sck_rise, sck_fall;
    logic [CW-1:0]     bit_cnt;
    logic              word_done;
    logic [WORD_W-1:0] rx_sr, tx_sr;
    logic              last_bit;

    assign sck_rise    = sck_s & ~sck_q;
    assign sck_fall    = ~sck_s & sck_q;
    assign frame_start = ~cs_s & cs_q;
    assign frame_end   = cs_s & ~cs_q;
    assign frame_clean = (bit_cnt == '0);
    assign last_bit    = (bit_cnt == CW'(WORD_W - 1));
    assign tx_take     = sck_fall & ~cs_s & word_done;
    assign tx_bit      = tx_sr[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            bit_cnt   <= '0;
            word_done <= 1'b0;
            rx_sr     <= '0;
            rx_word   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            sck_q    <= sck_s;
            cs_q     <= cs_s;
            rx_valid <= 1'b0;
            if (cs_s) begin
                bit_cnt   <= '0;
                word_done <= 1'b0;
            end else if (sck_rise) begin
                rx_sr     <= {rx_sr[WORD_W-2:0], mosi_s};
                bit_cnt   <= last_bit ? '0 : bit_cnt + 1'b1;
                word_done <= last_bit;
                if (last_bit) begin
                    rx_word  <= {rx_sr[WORD_W-2:0], mosi_s};
                    rx_valid <= 1'b1;
                end
            end else if (sck_fall) begin
                word_done <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (tx_preload) begin
            tx_sr <= tx_word;
        end else if (sck_fall && !cs_s) begin
            tx_sr <= word_done ? tx_word : {tx_sr[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_req_msg.sv
module spi_req_msg
    import spi_req_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [WORD_W-1:0]        rx_word,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic                     frame_clean,
    input  logic                     listen,
    output logic                     grant_p,
    output logic signed [WORD_W-1:0] c_re,
    output logic signed [WORD_W-1:0] c_im
);
    localparam int MAXW = 4;

    logic [WORD_W-1:0] wrd [MAXW];
    logic [2:0]        wcnt;
    logic              hdr_ok;

    assign hdr_ok = frame_end && frame_clean && listen && (wrd[0] == HDR_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt    <= '0;
            grant_p <= 1'b0;
            c_re    <= '0;
            c_im    <= '0;
            for (int i = 0; i < MAXW; i++) wrd[i] <= '0;
        end else begin
            grant_p <= 1'b0;
            if (frame_start) begin
                wcnt <= '0;
            end else if (rx_valid) begin
                if (wcnt < 3'(MAXW)) wrd[wcnt[1:0]] <= rx_word;
                if (wcnt != 3'(MAXW + 1)) wcnt <= wcnt + 1'b1;
            end
            if (hdr_ok) begin
                if (wcnt == 3'd2 && wrd[1] == CMD_GRANT) grant_p <= 1'b1;
                if (wcnt == 3'd4 && wrd[1] == CMD_CSET) begin
                    c_re <= wrd[2];
                    c_im <= wrd[3];
                end
            end
        end
    end

    // R3: a grant is only ever produced right after select rises
    a_r3_grant_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        grant_p |-> $past(frame_end));
    // R9: no constant update unless the decoder was listening
    a_r9_quiet_when_deaf: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(listen) |-> ($stable(c_re) && $stable(c_im)));
endmodule

// File: rtl/spi_req_target.sv
module spi_req_target
    import spi_req_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int TIMEOUT_CYC = 250_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [15:0]              buf_wdata,
    input  logic                     send_start,
    input  logic                     sck,
    input  logic                     cs_n,
    input  logic                     mosi,
    output logic                     miso_out,
    output logic                     miso_oe,
    output logic                     irq,
    output logic signed [15:0]       c_re,
    output logic signed [15:0]       c_im,
    output logic                     tx_err
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = $clog2(DEPTH + 1);
    localparam int TMO_W = $clog2(TIMEOUT_CYC);

    tgt_state_t state_q, state_d;

    logic              sck_s, cs_s, mosi_s;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_cnt, rd_ptr, sent;
    logic [TMO_W-1:0]  tmo;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic              rx_valid, frame_start, frame_end, frame_clean, tx_take;
    logic              grant_p, preload, listen, timeout_hit, last_word;

    spi_req_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sck, cs_n, mosi}), .q({sck_s, cs_s, mosi_s})
    );

    spi_req_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_s(sck_s), .cs_s(cs_s), .mosi_s(mosi_s),
        .tx_word(tx_word), .tx_preload(preload),
        .rx_word(rx_word), .rx_valid(rx_valid),
        .frame_start(frame_start), .frame_end(frame_end), .frame_clean(frame_clean),
        .tx_take(tx_take), .tx_bit(miso_out)
    );

    spi_req_msg u_msg (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_word(rx_word),
        .frame_start(frame_start), .frame_end(frame_end), .frame_clean(frame_clean),
        .listen(listen), .grant_p(grant_p), .c_re(c_re), .c_im(c_im)
    );

    assign tx_word     = (rd_ptr < PW'(DEPTH)) ? mem[rd_ptr[AW-1:0]] : '0;
    assign timeout_hit = (state_q == ST_REQ) && !grant_p && (tmo == TMO_W'(TIMEOUT_CYC - 1));
    assign last_word   = rx_valid && (sent == wr_cnt - PW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (send_start && wr_cnt != '0) state_d = ST_REQ;
            ST_REQ:  if (grant_p) state_d = ST_ARM;
                     else if (timeout_hit) state_d = ST_IDLE;
            ST_ARM:  state_d = ST_SEND;
            ST_SEND: if (last_word) state_d = ST_DONE;
            ST_DONE: if (cs_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        irq     = 1'b0;
        miso_oe = 1'b0;
        preload = 1'b0;
        listen  = 1'b0;
        unique case (state_q)
            ST_IDLE: listen = 1'b1;
            ST_REQ:  begin irq = 1'b1; listen = 1'b1; end
            ST_ARM:  begin miso_oe = 1'b1; preload = 1'b1; end
            ST_SEND: miso_oe = 1'b1;
            ST_DONE: miso_oe = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && buf_we && wr_cnt < PW'(DEPTH))
            mem[wr_cnt[AW-1:0]] <= buf_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
            sent   <= '0;
            tmo    <= '0;
            tx_err <= 1'b0;
        end else begin
            tmo <= (state_q == ST_REQ) ? tmo + 1'b1 : '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (buf_we && wr_cnt < PW'(DEPTH)) wr_cnt <= wr_cnt + 1'b1;
                    if (send_start) begin
                        tx_err <= 1'b0;
                        rd_ptr <= '0;
                    end
                end
                ST_REQ: if (timeout_hit) begin
                    tx_err <= 1'b1;
                    wr_cnt <= '0;
                end
                ST_ARM: begin
                    rd_ptr <= PW'(1);
                    sent   <= '0;
                end
                ST_SEND: begin
                    if (tx_take && rd_ptr < PW'(DEPTH)) rd_ptr <= rd_ptr + 1'b1;
                    if (rx_valid) sent <= sent + 1'b1;
                end
                ST_DONE: if (cs_s) wr_cnt <= '0;
                default: ;
            endcase
        end
    end

    // R3: request withdrawn the cycle after a grant is taken
    a_r3_irq_drops_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && grant_p) |=> !irq);
    // R3, R8: driver turns on only in answer to a grant
    a_r8_oe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(grant_p));
    // R4: driver turns off only once select is high
    a_r4_oe_off_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miso_oe) |-> cs_s);
    // R7: error flag appears together with request withdrawal
    a_r7_timeout_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err) |-> (!irq && $past(irq)));
endmodule

// File: tb/spi_req_target_test.sv
module spi_req_target_test;
    localparam int TMO = 3000;
    localparam int HP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_we = 1'b0;
    logic [15:0] buf_wdata = '0;
    logic send_start = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso_out, miso_oe, irq, tx_err;
    logic signed [15:0] c_re, c_im;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [15:0] txw [8];
    logic [15:0] rxw [8];

    always #10 clk = ~clk;

    spi_req_target #(.DEPTH(8), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .send_start(send_start), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso_out(miso_out), .miso_oe(miso_oe), .irq(irq),
        .c_re(c_re), .c_im(c_im), .tx_err(tx_err)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [15:0] w0, w1, w2, w3, er, ei;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd4, 16'hA5A5, 16'h0002, 16'h1234, 16'hFEDC, 16'h1234, 16'hFEDC},
        '{3'd4, 16'hA5A4, 16'h0002, 16'h1111, 16'h2222, 16'h1234, 16'hFEDC},
        '{3'd3, 16'hA5A5, 16'h0002, 16'h3333, 16'h0000, 16'h1234, 16'hFEDC},
        '{3'd4, 16'hA5A5, 16'h0003, 16'h4444, 16'h5555, 16'h1234, 16'hFEDC},
        '{3'd4, 16'hA5A5, 16'h0002, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
        '{3'd2, 16'hA5A5, 16'h0001, 16'h0000, 16'h0000, 16'h8000, 16'h7FFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_xfer(input int n, input int extra);
        cs_n = 1'b0;
        tick(HP);
        for (int w = 0; w < n; w++) begin
            for (int b = 15; b >= 0; b--) begin
                mosi = txw[w][b];
                tick(HP);
                rxw[w][b] = miso_out;
                sck = 1'b1;
                tick(HP);
                sck = 1'b0;
            end
        end
        for (int e = 0; e < extra; e++) begin
            mosi = 1'b0;
            tick(HP);
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
        tick(HP);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(3 * HP);
    endtask

    task automatic push(input logic [15:0] v);
        buf_we = 1'b1;
        buf_wdata = v;
        tick(1);
        buf_we = 1'b0;
    endtask

    task automatic start_send();
        send_start = 1'b1;
        tick(1);
        send_start = 1'b0;
        tick(4);
    endtask

    task automatic grant();
        txw[0] = 16'hA5A5;
        txw[1] = 16'h0001;
        spi_xfer(2, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] data [4];
        data[0] = 16'hC3A1; data[1] = 16'h0F0F; data[2] = 16'h8001; data[3] = 16'h7E55;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        chk(irq == 0, "R1 irq", 32'(irq), 0);
        chk(miso_oe == 0, "R1 miso_oe", 32'(miso_oe), 0);
        chk(tx_err == 0, "R1 tx_err", 32'(tx_err), 0);
        chk(c_re == 0 && c_im == 0, "R1 c", {c_re, c_im}, 0);

        // R5, R6, R8: table of MOSI messages
        for (int i = 0; i < 6; i++) begin
            txw[0] = VECS[i].w0; txw[1] = VECS[i].w1;
            txw[2] = VECS[i].w2; txw[3] = VECS[i].w3;
            spi_xfer(int'(VECS[i].n), 0);
            tick(10);
            chk({c_re, c_im} == {VECS[i].er, VECS[i].ei}, "R5/R6 table c", {c_re, c_im}, {VECS[i].er, VECS[i].ei});
            chk(miso_oe == 0 && irq == 0, "R6/R8 table oe irq", {miso_oe, irq}, 0);
        end

        // R6: message ending partway through a word
        txw[0] = 16'hA5A5; txw[1] = 16'h0002; txw[2] = 16'h0101; txw[3] = 16'h0202;
        spi_xfer(4, 3);
        tick(10);
        chk({c_re, c_im} == 32'h80007FFF, "R6 partial word", {c_re, c_im}, 32'h80007FFF);

        // R2: empty buffer start is ignored
        start_send();
        chk(irq == 0, "R2 empty start", 32'(irq), 0);

        // R2, R3, R4, R9: full send
        for (int i = 0; i < 4; i++) push(data[i]);
        start_send();
        chk(irq == 1, "R2 irq raised", 32'(irq), 1);
        chk(miso_oe == 0, "R3 oe before grant", 32'(miso_oe), 0);
        grant();
        chk(irq == 0, "R3 irq after grant", 32'(irq), 0);
        chk(miso_oe == 1, "R3 oe after grant", 32'(miso_oe), 1);
        chk(miso_out == data[0][15], "R3 preload msb", 32'(miso_out), 32'(data[0][15]));
        txw[0] = 16'hA5A5; txw[1] = 16'h0002; txw[2] = 16'h0BAD; txw[3] = 16'h0BAD;
        spi_xfer(4, 0);
        for (int i = 0; i < 4; i++)
            chk(rxw[i] == data[i], "R4 word stream", 32'(rxw[i]), 32'(data[i]));
        chk(miso_oe == 0, "R4 oe off after send", 32'(miso_oe), 0);
        chk({c_re, c_im} == 32'h80007FFF, "R9 mosi ignored in send", {c_re, c_im}, 32'h80007FFF);
        start_send();
        chk(irq == 0, "R2 buffer empty after send", 32'(irq), 0);

        // R7: timeout
        push(16'h1357); push(16'h2468);
        start_send();
        chk(irq == 1, "R7 request up", 32'(irq), 1);
        tick(TMO + 50);
        chk(irq == 0, "R7 irq cleared", 32'(irq), 0);
        chk(tx_err == 1, "R7 err set", 32'(tx_err), 1);
        grant();
        chk(miso_oe == 0, "R8 late grant ignored", 32'(miso_oe), 0);
        start_send();
        chk(irq == 0, "R7 buffer flushed", 32'(irq), 0);
        chk(tx_err == 0, "R7 err cleared", 32'(tx_err), 0);

        // R4: single-word send after recovery
        push(16'h5AF0);
        start_send();
        chk(irq == 1, "R2 single request", 32'(irq), 1);
        grant();
        txw[0] = 16'h0000;
        spi_xfer(1, 0);
        chk(rxw[0] == 16'h5AF0, "R4 single word", 32'(rxw[0]), 32'h5AF0);
        chk(miso_oe == 0, "R4 oe off single", 32'(miso_oe), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule